// File: doc/BRIEF.md
# STS-12 Frame and Byte Aligner

This block sits behind a clock and data recovery stage. It takes one recovered serial bit per bit clock and looks for the A1/A2 framing pattern. When it finds the pattern, it fixes the byte boundary at that bit offset and turns the stream into aligned 8-bit bytes. Each byte is marked by a one-cycle byte enable, so the bit clock stays the only clock and downstream logic runs at the byte rate on that enable.

After alignment the block counts byte positions through the frame. The frame is a number of rows times a number of columns: 9 rows of 1080 bytes by default, which gives 9720 bytes in each 125 us frame. The framing check is repeated at the expected position in every frame. A small state machine decides between hunting, provisional lock and in-frame, and drives the out-of-frame flag. A frame pulse marks the first A2 byte on the parallel output.

Top module: `sts_aligner`

## Requirements
- R1: While reset is held, and on leaving it, `oof` is 1 and both `byte_en` and `frame_pulse` are 0.
- R2: While hunting, a 16-bit window equal to 0xF628 is recognised at any bit offset. This is the last A1 (0xF6) followed by the first A2 (0x28), both sent MSB first. From then on, `byte_out` carries the transmitted bytes exactly, MSB first, starting with that first A2.
- R3: Once aligned, `byte_en` pulses for one bit-clock cycle every 8 bit clocks, and `byte_out` is valid in that cycle.
- R4: `frame_pulse` is high for one `byte_en` cycle, together with the first A2 byte. A2 follows `N_A1` A1 bytes (12 by default), so the first A2 is at frame byte index `N_A1`. The pulse comes at the hunt match and at each expected framing position while not hunting. It never comes on any other byte.
- R5: A match at the expected position in the frame that follows the hunt match clears `oof`, so two consecutive good frames give in-frame.
- R6: A mismatch at the expected position during provisional lock returns the block to hunting with `oof` still 1. A frame that has no match while hunting leaves `oof` at 1 and gives no `frame_pulse`.
- R7: While in frame, one to three consecutive mismatches keep `oof` at 0. A good frame resets the mismatch run.
- R8: The fourth consecutive mismatch sets `oof` on the byte at that frame's framing position and restarts the hunt.
- R9: The expected framing position recurs every `ROWS*COLS` bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Recovered serial data, MSB of each byte first |
| byte_en | output | 1 | One-cycle strobe marking a new aligned byte |
| byte_out | output | 8 | Aligned byte, valid with `byte_en` |
| frame_pulse | output | 1 | Marks the first A2 byte of a frame |
| oof | output | 1 | Out-of-frame indicator |

## Verification
The bench starts the pattern at two different bit offsets after reset. A design that got the bit slip wrong would deliver bytes rotated by a few bits, and every payload compare would fail. A frame with a corrupted first A2 is sent during provisional lock, and again in runs of one and four while in frame. A design with off-by-one confirm or drop counters would change `oof` one frame early or late. A design that did not clear its mismatch run after a good frame would drop lock after the split run. The bench also sends a corrupted frame while hunting. This catches a design that pulses `frame_pulse` without a match, and a design that counts the frame position from the wrong byte, which would put the pulse on an A1 or payload byte.

// File: rtl/sts_align_pkg.sv
package sts_align_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_PRE  = 2'd1,
    ST_SYNC = 2'd2
  } frm_st_e;

  localparam logic [7:0] A1_BYTE = 8'hF6;
  localparam logic [7:0] A2_BYTE = 8'h28;
endpackage

// File: rtl/sa_deser.sv
module sa_deser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_i,
  input  logic        slip_i,
  output logic [15:0] win_o,
  output logic        bnd_o
);
  logic [2:0]  ph_q;
  logic [2:0]  ph_d;
  logic [15:0] win_d;

  always_comb begin
    win_d = {win_o[14:0], ser_i};
    ph_d  = slip_i ? 3'd0 : ph_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_o <= '0;
      ph_q  <= '0;
    end else begin
      win_o <= win_d;
      ph_q  <= ph_d;
    end
  end

  // a byte is complete when eight bits have entered since the last boundary,
  // or immediately when the hunt fixes a new boundary
  assign bnd_o = slip_i | (ph_q == 3'd7);

  // R3: after a slip the next boundary is eight bits away
  a_r3_slip_restart: assert property (@(posedge clk) disable iff (!rst_n)
    slip_i |=> (ph_q == 3'd0));
endmodule

// File: rtl/sa_pos_cnt.sv
module sa_pos_cnt #(
  parameter int FRAME = 9720,
  parameter int START = 12,
  localparam int PW = $clog2(FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          load_i,
  output logic [PW-1:0] idx_o
);
  localparam logic [PW-1:0] START_V = PW'(START);
  localparam logic [PW-1:0] LAST_V  = PW'(FRAME - 1);

  logic [PW-1:0] pos_q;
  logic [PW-1:0] pos_d;

  always_comb begin
    idx_o = load_i ? START_V : pos_q;
    pos_d = pos_q;
    if (step_i) pos_d = (idx_o == LAST_V) ? '0 : idx_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  // R9: position stays inside the frame and wraps at its end
  a_r9_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST_V);
  a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && idx_o == LAST_V) |=> (pos_q == '0));
endmodule

// File: rtl/sa_frame_fsm.sv
module sa_frame_fsm
  import sts_align_pkg::*;
#(
  parameter int GOOD_FRAMES = 2,
  parameter int BAD_FRAMES  = 4,
  localparam int GW = $clog2(GOOD_FRAMES + 1),
  localparam int BW = $clog2(BAD_FRAMES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic found_i,
  input  logic chk_i,
  input  logic ok_i,
  output logic hunt_o,
  output logic oof_o
);
  frm_st_e       st_q, st_d;
  logic [GW-1:0] g_q, g_d;
  logic [BW-1:0] b_q, b_d;

  always_comb begin
    st_d = st_q;
    g_d  = g_q;
    b_d  = b_q;
    case (st_q)
      ST_HUNT: if (found_i) begin
        st_d = ST_PRE;
        g_d  = GW'(1);
        b_d  = '0;
      end
      ST_PRE: if (chk_i) begin
        if (!ok_i) st_d = ST_HUNT;
        else if (g_q == GW'(GOOD_FRAMES - 1)) begin
          st_d = ST_SYNC;
          b_d  = '0;
        end else g_d = g_q + 1'b1;
      end
      ST_SYNC: if (chk_i) begin
        if (ok_i) b_d = '0;
        else if (b_q == BW'(BAD_FRAMES - 1)) st_d = ST_HUNT;
        else b_d = b_q + 1'b1;
      end
      default: st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_HUNT;
      g_q  <= '0;
      b_q  <= '0;
    end else begin
      st_q <= st_d;
      g_q  <= g_d;
      b_q  <= b_d;
    end
  end

  assign hunt_o = (st_q == ST_HUNT);
  assign oof_o  = (st_q != ST_SYNC);

  // R5: in-frame is only reached from provisional lock on a good check
  a_r5_clear_from_pre: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oof_o) |-> $past(st_q == ST_PRE && chk_i && ok_i));
  // R8: out-of-frame only rises on a failed check
  a_r8_set_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oof_o) |-> $past(chk_i && !ok_i));
  // R7: a good check while in frame keeps the block in frame
  a_r7_good_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SYNC && chk_i && ok_i) |=> !oof_o);
endmodule

// File: rtl/sts_aligner.sv
module sts_aligner
  import sts_align_pkg::*;
#(
  parameter int ROWS        = 9,
  parameter int COLS        = 1080,
  parameter int N_A1        = 12,
  parameter int GOOD_FRAMES = 2,
  parameter int BAD_FRAMES  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_in,
  output logic       byte_en,
  output logic [7:0] byte_out,
  output logic       frame_pulse,
  output logic       oof
);
  localparam int FRAME = ROWS * COLS;
  localparam int PW    = $clog2(FRAME);
  localparam logic [PW-1:0] A2_IDX = PW'(N_A1);
  localparam logic [15:0]   FPAT   = {A1_BYTE, A2_BYTE};

  logic [15:0]   win;
  logic          bnd, hunt, match, slip, chk;
  logic [PW-1:0] idx;
  logic          en_d, fp_d;
  logic [7:0]    dat_d;

  assign match = (win == FPAT);
  assign slip  = hunt & match;
  assign chk   = bnd & ~hunt & (idx == A2_IDX);

  sa_deser u_deser (
    .clk   (clk),
    .rst_n (rst_n),
    .ser_i (ser_in),
    .slip_i(slip),
    .win_o (win),
    .bnd_o (bnd)
  );

  sa_pos_cnt #(.FRAME(FRAME), .START(N_A1)) u_pos (
    .clk   (clk),
    .rst_n (rst_n),
    .step_i(bnd),
    .load_i(slip),
    .idx_o (idx)
  );

  sa_frame_fsm #(.GOOD_FRAMES(GOOD_FRAMES), .BAD_FRAMES(BAD_FRAMES)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .found_i(slip),
    .chk_i  (chk),
    .ok_i   (match),
    .hunt_o (hunt),
    .oof_o  (oof)
  );

  always_comb begin
    en_d  = bnd;
    fp_d  = slip | chk;
    dat_d = bnd ? win[7:0] : byte_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_en     <= 1'b0;
      frame_pulse <= 1'b0;
      byte_out    <= '0;
    end else begin
      byte_en     <= en_d;
      frame_pulse <= fp_d;
      byte_out    <= dat_d;
    end
  end

  // R4: a frame pulse always rides on a byte strobe
  a_r4_fp_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> byte_en);
  // R2: a hunt match delivers the first A2 byte with a frame pulse
  a_r2_find_delivers_a2: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> (frame_pulse && byte_out == A2_BYTE));
endmodule

// File: tb/sim_sts_aligner.sv
module sim_sts_aligner;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 2;
  localparam int COLS = 40;
  localparam int FR   = ROWS * COLS;
  localparam int N_A1 = 12;
  localparam int N_A2 = 12;

  typedef struct {
    logic [7:0] d;
    logic       fp;
    logic       oof;
    string      ftag;
    string      otag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic ser_in;
  logic byte_en, frame_pulse, oof;
  logic [7:0] byte_out;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  bit started = 0;
  bit have_prev = 0;
  int gap = 0;

  // reference model of the lock rules
  int  mst = 0;
  int  mbad = 0;
  bit  mstart = 0;
  int  mfrm = 0;
  string otag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  sts_aligner #(.ROWS(ROWS), .COLS(COLS), .N_A1(N_A1)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
    .byte_en(byte_en), .byte_out(byte_out),
    .frame_pulse(frame_pulse), .oof(oof)
  );

  task automatic chk1(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items as aligned bytes appear
  always @(negedge clk) begin
    gap++;
    if (rst_n && byte_en) begin
      if (!started && frame_pulse) started = 1;
      if (started && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk1("R2", int'(byte_out), int'(e.d), "byte_out");
        chk1(e.ftag, int'(frame_pulse), int'(e.fp), "frame_pulse");
        chk1(e.otag, int'(oof), int'(e.oof), "oof");
        if (have_prev) chk1("R3", gap, 8, "byte_en spacing");
        have_prev = 1;
      end
      gap = 0;
    end
  end

  task automatic send_bit(logic b);
    @(negedge clk);
    ser_in = b;
  endtask

  task automatic send_bits(int n, logic b);
    for (int i = 0; i < n; i++) send_bit(b);
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ser_in = 1'b0;
    repeat (3) @(negedge clk);
    chk1("R1", int'(oof), 1, "oof in reset");
    chk1("R1", int'(byte_en), 0, "byte_en in reset");
    chk1("R1", int'(frame_pulse), 0, "frame_pulse in reset");
    q.delete();
    started = 0; have_prev = 0;
    mst = 0; mbad = 0; mstart = 0; mfrm = 0; otag = "R2";
    rst_n = 1'b1;
    @(negedge clk);
    chk1("R1", int'(oof), 1, "oof after reset");
  endtask

  // model: state 0 hunt, 1 provisional, 2 in frame
  task automatic send_frame(bit bad);
    logic [7:0] b;
    bit fpe;
    string ft;
    for (int idx = 0; idx < FR; idx++) begin
      if (idx < N_A1) b = 8'hF6;
      else if (idx < N_A1 + N_A2) b = 8'h28;
      else b = {4'h0, 4'(idx)};
      if (bad && idx == N_A1) b = 8'h00;
      fpe = 0;
      if (idx == N_A1) begin
        if (mst == 0) begin
          if (!bad) begin mst = 1; fpe = 1; mstart = 1; otag = "R2"; end
          else otag = "R6";
        end else if (mst == 1) begin
          fpe = 1;
          if (!bad) begin mst = 2; mbad = 0; otag = "R5"; end
          else begin mst = 0; otag = "R6"; end
        end else begin
          fpe = 1;
          if (!bad) begin mbad = 0; otag = "R7"; end
          else begin
            mbad++;
            if (mbad == 4) begin mst = 0; otag = "R8"; end
            else otag = "R7";
          end
        end
      end
      ft = (mfrm == 0) ? "R4" : "R9";
      if (mstart) begin
        exp_t e;
        e.d = b; e.fp = fpe; e.oof = (mst != 2); e.ftag = ft; e.otag = otag;
        q.push_back(e);
      end
      send_byte(b);
    end
    mfrm++;
  endtask

  task automatic finish_phase();
    send_bits(16, 1'b0);
    repeat (20) @(negedge clk);
    chk1("R2", q.size(), 0, "pending expected bytes");
  endtask

  initial begin
    bit pa[12] = '{0,0,0,1,0,1,1,1,1,1,0,0};
    bit pb[5]  = '{0,1,0,0,0};
    rst_n = 1'b0;
    ser_in = 1'b0;
    do_reset();
    send_bits(5, 1'b0);
    foreach (pa[i]) send_frame(pa[i]);
    finish_phase();
    do_reset();
    send_bits(3, 1'b1);
    foreach (pb[i]) send_frame(pb[i]);
    finish_phase();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule